// File: doc/BRIEF.md
# Reconfiguration Page Select Controller

This block sits on a simple synchronous register bus and decides which of eight flash pages the next device reconfiguration loads from. The page can come from two places. One is a software-written page register. The other is a live rotary switch input, passed through a synchronizer first. A software-written override bit picks between them.

Software starts a reconfiguration by writing the value zero to a write-only trigger register. Any nonzero value written there is ignored. A zero write produces a one-cycle request pulse on the next clock. Alongside the pulse, the block presents the page that was selected at the moment of the write, and it keeps that page stable until the next zero write. Register writes act on the very next clock edge; there is no commit step.

Register map, using a 4-bit address:

| Address | Access | Contents |
|---|---|---|
| 0x0 | read/write | Page register |
| 0x1 | read/write | Override bit |
| 0x2 | read-only | Synchronized switch |
| 0x3 | write-only | Reconfiguration trigger |

Top module: `pagesel_ctrl`

## Requirements
- R1: After reset the page register is 0, the override bit is 0, reconf_req is low and reconf_page is 0.
- R2: A write to address 0x0 stores data bits [2:0] as the page. A read of 0x0 returns the page in bits [2:0] and zero in every higher bit.
- R3: A write to address 0x1 stores data bit 0 as the override bit. A read of 0x1 returns the bit in bit 0 and zero in every higher bit.
- R4: A read of address 0x2 returns the switch input after a two-flop synchronizer. A switch change is readable by the second clock edge after it, and the upper bits read as zero.
- R5: Writes to address 0x2 leave the page register, the override bit and the switch readback unchanged.
- R6: Writing all-zero data to address 0x3 raises reconf_req for exactly the one cycle after the write edge.
- R7: Writing any nonzero value to address 0x3 leaves reconf_req low.
- R8: On a request, reconf_page equals the page register when the override bit is 0, and the synchronized switch value when it is 1. Both are taken as they stood in the cycle of the write.
- R9: reconf_page keeps its value in every cycle that does not follow a zero write to 0x3.
- R10: A read of address 0x3 returns all ones.
- R11: Addresses 0x4 to 0xF read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (4) | Register address |
| bus_we | input | 1 | Write enable, one write per cycle |
| bus_wdata | input | DATA_W (8) | Write data |
| bus_rdata | output | DATA_W (8) | Read data for bus_addr, combinational |
| switch_raw | input | PAGE_W (3) | Asynchronous rotary switch position |
| reconf_req | output | 1 | One-cycle reconfiguration request |
| reconf_page | output | PAGE_W (3) | Page for the latest request, held between requests |

## Verification
The assertions assume a few things about the inputs:
- The bus carries at most one write per cycle.
- Address and data are stable around the clock edge.
- The switch input may change at any time, because it is only observed through the synchronizer.

The stimulus drives every bus field and the switch on the falling edge, and it performs writes one at a time. It sweeps every page, override and switch combination and every nonzero trigger value. Before each trigger, the switch is left settled for three cycles.

// File: rtl/pagesel_pkg.sv
package pagesel_pkg;
    localparam int unsigned ADDR_PAGE = 0;
    localparam int unsigned ADDR_OVR  = 1;
    localparam int unsigned ADDR_SW   = 2;
    localparam int unsigned ADDR_TRIG = 3;
endpackage

// File: rtl/pagesel_sync.sv
module pagesel_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/pagesel_regs.sv
module pagesel_regs
    import pagesel_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned PAGE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [PAGE_W-1:0] sw_sync,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [PAGE_W-1:0] page_o,
    output logic              ovr_o
);
    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic              ovr;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (bus_we) begin
            if (bus_addr == ADDR_W'(ADDR_PAGE)) regs_d.page = bus_wdata[PAGE_W-1:0];
            if (bus_addr == ADDR_W'(ADDR_OVR))  regs_d.ovr  = bus_wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        bus_rdata = '0;
        if      (bus_addr == ADDR_W'(ADDR_PAGE)) bus_rdata = DATA_W'(regs_q.page);
        else if (bus_addr == ADDR_W'(ADDR_OVR))  bus_rdata = DATA_W'(regs_q.ovr);
        else if (bus_addr == ADDR_W'(ADDR_SW))   bus_rdata = DATA_W'(sw_sync);
        else if (bus_addr == ADDR_W'(ADDR_TRIG)) bus_rdata = '1;
    end

    assign page_o = regs_q.page;
    assign ovr_o  = regs_q.ovr;

    // R5 and R11: writes outside the two writable addresses leave the state alone
    assert_ro_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr != ADDR_W'(ADDR_PAGE) && bus_addr != ADDR_W'(ADDR_OVR))
        |=> ($stable(page_o) && $stable(ovr_o)));

    // R2: a page write is visible on the next cycle
    assert_page_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(ADDR_PAGE))
        |=> page_o == $past(bus_wdata[PAGE_W-1:0]));
endmodule

// File: rtl/pagesel_trigger.sv
module pagesel_trigger #(
    parameter int unsigned PAGE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [PAGE_W-1:0] sel_page,
    output logic              req,
    output logic [PAGE_W-1:0] page
);
    typedef struct packed {
        logic              req;
        logic [PAGE_W-1:0] page;
    } trig_t;

    trig_t trig_d, trig_q;

    always_comb begin
        trig_d     = trig_q;
        trig_d.req = fire;
        if (fire) trig_d.page = sel_page;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= '0;
        else        trig_q <= trig_d;
    end

    assign req  = trig_q.req;
    assign page = trig_q.page;

    assert_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> req);
    assert_no_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> !req);
    assert_page_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(page));
endmodule

// File: rtl/pagesel_ctrl.sv
module pagesel_ctrl
    import pagesel_pkg::*;
#(
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned PAGE_W      = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PAGE_W-1:0] switch_raw,
    output logic              reconf_req,
    output logic [PAGE_W-1:0] reconf_page
);
    logic [PAGE_W-1:0] sw_sync;
    logic [PAGE_W-1:0] reg_page;
    logic              reg_ovr;
    logic [PAGE_W-1:0] sel_page;
    logic              fire;

    pagesel_sync #(.WIDTH(PAGE_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(switch_raw), .dout(sw_sync)
    );

    pagesel_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .sw_sync(sw_sync), .bus_rdata(bus_rdata),
        .page_o(reg_page), .ovr_o(reg_ovr)
    );

    assign sel_page = reg_ovr ? sw_sync : reg_page;
    assign fire     = bus_we && (bus_addr == ADDR_W'(ADDR_TRIG)) && (bus_wdata == '0);

    pagesel_trigger #(.PAGE_W(PAGE_W)) u_trig (
        .clk(clk), .rst_n(rst_n), .fire(fire), .sel_page(sel_page),
        .req(reconf_req), .page(reconf_page)
    );

    // R8: the request carries the page from the selected source
    assert_src_reg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reconf_req && $past(!reg_ovr)) |-> reconf_page == $past(reg_page));
    assert_src_sw_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reconf_req && $past(reg_ovr)) |-> reconf_page == $past(sw_sync));
    // R10: the trigger address reads all ones
    assert_trig_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(ADDR_TRIG)) |-> (&bus_rdata));
endmodule

// File: tb/tb_pagesel_ctrl.sv
module tb_pagesel_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [2:0] switch_raw = '0;
    logic       reconf_req;
    logic [2:0] reconf_page;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pagesel_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .switch_raw(switch_raw),
        .reconf_req(reconf_req), .reconf_page(reconf_page)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // write on the next edge; returns at the falling edge after that write edge
    task automatic wr(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic set_switch(logic [2:0] s);
        @(negedge clk);
        switch_raw = s;
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        int v;
        int held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(4'h0, v); check("R1 page", v, 0);
        rd(4'h1, v); check("R1 ovr", v, 0);
        check("R1 req", int'(reconf_req), 0);
        check("R1 reconf_page", int'(reconf_page), 0);
        rd(4'h3, v); check("R10 trig read", v, 255);

        // R2 page register, every value plus set upper bits
        for (int p = 0; p < 8; p++) begin
            wr(4'h0, 8'(p) | 8'hF8);
            rd(4'h0, v); check("R2 page readback", v, p);
        end

        // R3 override bit
        wr(4'h1, 8'hFE); rd(4'h1, v); check("R3 ovr clear", v, 0);
        wr(4'h1, 8'h03); rd(4'h1, v); check("R3 ovr set", v, 1);
        wr(4'h1, 8'h00);

        // R4 switch synchronizer latency and readback
        for (int s = 0; s < 8; s++) begin
            @(negedge clk);
            switch_raw = 3'(s);
            @(negedge clk);
            @(negedge clk);
            rd(4'h2, v); check("R4 switch read", v, s);
        end

        // R5 switch writes ignored
        wr(4'h0, 8'h06); wr(4'h1, 8'h00);
        set_switch(3'd3);
        wr(4'h2, 8'hFF);
        rd(4'h2, v); check("R5 switch unchanged", v, 3);
        rd(4'h0, v); check("R5 page unchanged", v, 6);
        rd(4'h1, v); check("R5 ovr unchanged", v, 0);

        // R11 unmapped addresses
        for (int a = 4; a < 16; a++) begin
            wr(4'(a), 8'hFF);
            rd(4'(a), v); check("R11 unmapped read", v, 0);
        end
        rd(4'h0, v); check("R11 page unchanged", v, 6);
        rd(4'h1, v); check("R11 ovr unchanged", v, 0);

        // R6 R8 R9: full sweep of source, page and switch
        for (int o = 0; o < 2; o++) begin
            for (int p = 0; p < 8; p++) begin
                for (int s = 0; s < 8; s++) begin
                    wr(4'h0, 8'(p));
                    wr(4'h1, 8'(o));
                    set_switch(3'(s));
                    check("R6 idle before", int'(reconf_req), 0);
                    wr(4'h3, 8'h00);
                    check("R6 pulse", int'(reconf_req), 1);
                    check("R8 page source", int'(reconf_page), (o == 1) ? s : p);
                    held = (o == 1) ? s : p;
                    @(negedge clk);
                    check("R6 single cycle", int'(reconf_req), 0);
                    check("R9 page held", int'(reconf_page), held);
                end
            end
        end

        // R7 R9: nonzero trigger values do nothing
        wr(4'h1, 8'h00); wr(4'h0, 8'h05); wr(4'h3, 8'h00);
        held = 5;
        wr(4'h0, 8'h02);
        for (int d = 1; d < 256; d++) begin
            wr(4'h3, 8'(d));
            check("R7 no pulse", int'(reconf_req), 0);
            check("R9 page held", int'(reconf_page), held);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule